// File: doc/BRIEF.md
# Two-Wire Bus Clock Timeout Monitor

This block watches the clock and data lines of a two-wire serial bus and reports two timing conditions. A stuck-bus guard counts how long the clock line stays low. When one low period lasts longer than a programmed number of cycles, it raises a timeout flag. After a further programmed delay it emits a one-cycle strobe that asks the surrounding controller to reset its communication state. The master cannot pull a held-low clock line high, so this reset strobe is the only recovery path.

An idle guard counts how long both lines have been high together. After enough cycles it declares the bus free. A master that has a START waiting holds a request input high. The monitor answers with a one-cycle grant strobe once the bus is free, and the grant uses up that idle period.

Both raw lines pass through a two-flop synchronizer before any counting. All three limits are cycle counts supplied on input ports, so one build covers any clock rate. The nominal values are 25 ms for the low limit, a reset delay no greater than 10 ms, and 50 µs for the idle limit.

Top module: `twb_timeout_monitor`

## Requirements
- R1: Each raw line passes through two flops, so a raw change first affects the counters two clock edges after it is applied.
- R2: `tmo_flag` rises only when the synchronized clock line has stayed low for more than `lo_max_cyc` consecutive cycles. A low period of `lo_max_cyc` cycles or fewer never raises it.
- R3: `comm_rst` is high for exactly one cycle, `rst_wait_cyc + 1` cycles after `tmo_flag` rises. `tmo_flag` falls in the same cycle that `comm_rst` is high.
- R4: Each low period produces at most one timeout, however long the line stays low. The low-time count restarts from zero whenever the clock line is high.
- R5: `bus_free` rises once both synchronized lines have been high for more than `idle_min_cyc` consecutive cycles. It falls as soon as either synchronized line is low.
- R6: `start_grant` is a one-cycle pulse. It fires only in the cycle after both `bus_free` and `start_req` were high with both lines still high. `bus_free` is low while the grant pulse is high.
- R7: After a grant, no further grant and no `bus_free` occur until a line has gone low and a new, complete idle period has elapsed.
- R8: The low-time and high-time counters saturate at their limits and never wrap back to zero.
- R9: After a synchronous reset, all four outputs are low. Both synchronizers hold the idle-high level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_raw | input | 1 | Raw bus clock line, not yet synchronized |
| sda_raw | input | 1 | Raw bus data line, not yet synchronized |
| start_req | input | 1 | A master START is waiting |
| lo_max_cyc | input | CNT_W | Longest clock-low period allowed, in cycles |
| rst_wait_cyc | input | CNT_W | Delay from the timeout flag to the reset strobe, minus one |
| idle_min_cyc | input | CNT_W | Both-high time needed to declare the bus free, in cycles |
| tmo_flag | output | 1 | A clock-low timeout is pending |
| comm_rst | output | 1 | One-cycle request to reset communication |
| bus_free | output | 1 | The bus has been idle long enough |
| start_grant | output | 1 | One-cycle permission to issue the waiting START |

## Verification
The assertions assume that the three limit inputs stay constant outside reset. This matters most for the saturation checks: lowering a limit below a running count would break the bound on that count. The assertions also assume `rst_wait_cyc` fits the counter width. The stimulus sets all three limits once, before reset is released, and never changes them. All limits are set well below the range of the six-bit counter chosen for the bench. Raw line changes and `start_req` are driven one time unit after a clock edge, so each one reaches the synchronizer as a clean level.

// File: rtl/twb_tmo_pkg.sv
package twb_tmo_pkg;
    localparam int unsigned DEF_CNT_W = 24;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;
endpackage

// File: rtl/twb_sync2.sv
module twb_sync2 #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] meta_d;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] sync_d;

    always_comb begin
        meta_d = din;
        sync_d = meta_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/twb_low_guard.sv
module twb_low_guard #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_s,
    input  logic [CNT_W-1:0] lo_max_cyc,
    input  logic [CNT_W-1:0] rst_wait_cyc,
    output logic [CNT_W-1:0] low_cnt,
    output logic             tmo_flag,
    output logic             comm_rst
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fired;
        logic             tmo;
        logic [CNT_W-1:0] dly;
        logic             pulse;
    } low_st_t;

    low_st_t st_d;
    low_st_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;

        if (st_q.tmo) begin
            if (st_q.dly >= rst_wait_cyc) begin
                st_d.tmo   = 1'b0;
                st_d.pulse = 1'b1;
                st_d.dly   = '0;
            end else begin
                st_d.dly = st_q.dly + CNT_W'(1);
            end
        end

        if (scl_s) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else begin
            if (st_q.cnt < lo_max_cyc) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            if (st_q.cnt >= lo_max_cyc && !st_q.fired) begin
                st_d.fired = 1'b1;
                st_d.tmo   = 1'b1;
                st_d.dly   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign low_cnt  = st_q.cnt;
    assign tmo_flag = st_q.tmo;
    assign comm_rst = st_q.pulse;
endmodule

// File: rtl/twb_idle_guard.sv
module twb_idle_guard #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             start_req,
    input  logic [CNT_W-1:0] idle_min_cyc,
    output logic [CNT_W-1:0] hi_cnt,
    output logic             bus_free,
    output logic             start_grant
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             used;
        logic             free;
        logic             grant;
    } idle_st_t;

    idle_st_t st_d;
    idle_st_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;

        if (!(scl_s && sda_s)) begin
            st_d.cnt  = '0;
            st_d.used = 1'b0;
            st_d.free = 1'b0;
        end else begin
            if (st_q.cnt < idle_min_cyc) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            if (st_q.free && start_req) begin
                st_d.free  = 1'b0;
                st_d.used  = 1'b1;
                st_d.grant = 1'b1;
            end else if (st_q.cnt >= idle_min_cyc && !st_q.used) begin
                st_d.free = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_cnt      = st_q.cnt;
    assign bus_free    = st_q.free;
    assign start_grant = st_q.grant;
endmodule

// File: rtl/twb_timeout_monitor.sv
module twb_timeout_monitor
    import twb_tmo_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_raw,
    input  logic             sda_raw,
    input  logic             start_req,
    input  logic [CNT_W-1:0] lo_max_cyc,
    input  logic [CNT_W-1:0] rst_wait_cyc,
    input  logic [CNT_W-1:0] idle_min_cyc,
    output logic             tmo_flag,
    output logic             comm_rst,
    output logic             bus_free,
    output logic             start_grant
);
    localparam int unsigned LINES = $bits(line_pair_t);

    line_pair_t       raw_pair;
    line_pair_t       sync_pair;
    logic             scl_s;
    logic             sda_s;
    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] hi_cnt;

    assign raw_pair.scl = scl_raw;
    assign raw_pair.sda = sda_raw;

    twb_sync2 #(.WIDTH(LINES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_pair),
        .dout (sync_pair)
    );

    assign scl_s = sync_pair.scl;
    assign sda_s = sync_pair.sda;

    twb_low_guard #(.CNT_W(CNT_W)) u_low (
        .clk          (clk),
        .rst          (rst),
        .scl_s        (scl_s),
        .lo_max_cyc   (lo_max_cyc),
        .rst_wait_cyc (rst_wait_cyc),
        .low_cnt      (low_cnt),
        .tmo_flag     (tmo_flag),
        .comm_rst     (comm_rst)
    );

    twb_idle_guard #(.CNT_W(CNT_W)) u_idle (
        .clk          (clk),
        .rst          (rst),
        .scl_s        (scl_s),
        .sda_s        (sda_s),
        .start_req    (start_req),
        .idle_min_cyc (idle_min_cyc),
        .hi_cnt       (hi_cnt),
        .bus_free     (bus_free),
        .start_grant  (start_grant)
    );
endmodule

// File: rtl/twb_timeout_monitor_chk.sv
module twb_timeout_monitor_chk #(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_s,
    input logic             sda_s,
    input logic             start_req,
    input logic [CNT_W-1:0] low_cnt,
    input logic [CNT_W-1:0] hi_cnt,
    input logic [CNT_W-1:0] lo_max_cyc,
    input logic [CNT_W-1:0] idle_min_cyc,
    input logic             tmo_flag,
    input logic             comm_rst,
    input logic             bus_free,
    input logic             start_grant
);
    assert_rise_needs_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_flag) |-> !$past(scl_s));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        comm_rst |=> !comm_rst);

    assert_flag_drops_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(comm_rst) |-> (!tmo_flag && $past(tmo_flag)));

    assert_free_needs_idle_R5: assert property (@(posedge clk) disable iff (rst)
        bus_free |-> ($past(scl_s) && $past(sda_s)));

    assert_grant_cause_R6: assert property (@(posedge clk) disable iff (rst)
        start_grant |-> ($past(bus_free) && $past(start_req)));

    assert_grant_consumes_R7: assert property (@(posedge clk) disable iff (rst)
        start_grant |-> (!bus_free ##1 !start_grant));

    assert_low_sat_R8: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= lo_max_cyc);

    assert_high_sat_R8: assert property (@(posedge clk) disable iff (rst)
        hi_cnt <= idle_min_cyc);
endmodule

bind twb_timeout_monitor twb_timeout_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_s        (scl_s),
    .sda_s        (sda_s),
    .start_req    (start_req),
    .low_cnt      (low_cnt),
    .hi_cnt       (hi_cnt),
    .lo_max_cyc   (lo_max_cyc),
    .idle_min_cyc (idle_min_cyc),
    .tmo_flag     (tmo_flag),
    .comm_rst     (comm_rst),
    .bus_free     (bus_free),
    .start_grant  (start_grant)
);

// File: tb/twb_timeout_monitor_bench.sv
`timescale 1ns/1ps
module twb_timeout_monitor_bench;
    localparam int unsigned CNT_W = 6;
    localparam int LO  = 20;
    localparam int DLY = 5;
    localparam int IDL = 8;

    // vector: [8] kind (0 = clock-low pulse, 1 = idle window), [7:1] length, [0] expected
    localparam int NVEC = 8;
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 7'd5,  1'b0},
        {1'b0, 7'd20, 1'b0},
        {1'b0, 7'd21, 1'b1},
        {1'b0, 7'd40, 1'b1},
        {1'b1, 7'd4,  1'b0},
        {1'b1, 7'd8,  1'b0},
        {1'b1, 7'd9,  1'b1},
        {1'b1, 7'd25, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             scl_raw = 1'b1;
    logic             sda_raw = 1'b1;
    logic             start_req = 1'b0;
    logic [CNT_W-1:0] lo_max_cyc   = CNT_W'(LO);
    logic [CNT_W-1:0] rst_wait_cyc = CNT_W'(DLY);
    logic [CNT_W-1:0] idle_min_cyc = CNT_W'(IDL);
    logic             tmo_flag;
    logic             comm_rst;
    logic             bus_free;
    logic             start_grant;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    twb_timeout_monitor #(.CNT_W(CNT_W)) u_twb_timeout_monitor (
        .clk          (clk),
        .rst          (rst),
        .scl_raw      (scl_raw),
        .sda_raw      (sda_raw),
        .start_req    (start_req),
        .lo_max_cyc   (lo_max_cyc),
        .rst_wait_cyc (rst_wait_cyc),
        .idle_min_cyc (idle_min_cyc),
        .tmo_flag     (tmo_flag),
        .comm_rst     (comm_rst),
        .bus_free     (bus_free),
        .start_grant  (start_grant)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seen;
        int pulses;
        int grants;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R9 reset state
        chk("R9 tmo_flag", tmo_flag, 0);
        chk("R9 comm_rst", comm_rst, 0);
        chk("R9 bus_free", bus_free, 0);
        chk("R9 start_grant", start_grant, 0);
        tick(5);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            int len;
            len = int'(VEC[v][7:1]);
            seen = 0;
            pulses = 0;
            if (VEC[v][8] == 1'b0) begin
                scl_raw = 1'b0;
                for (int i = 0; i < len; i++) begin
                    tick(1);
                    seen |= int'(tmo_flag);
                    pulses += int'(comm_rst);
                end
                scl_raw = 1'b1;
                for (int i = 0; i < 40; i++) begin
                    tick(1);
                    seen |= int'(tmo_flag);
                    pulses += int'(comm_rst);
                end
                chk($sformatf("R2 timeout for low length %0d", len), seen, int'(VEC[v][0]));
                chk($sformatf("R3 strobe count for low length %0d", len), pulses, int'(VEC[v][0]));
            end else begin
                sda_raw = 1'b0;
                tick(4);
                sda_raw = 1'b1;
                for (int i = 0; i < len; i++) begin
                    tick(1);
                    seen |= int'(bus_free);
                end
                sda_raw = 1'b0;
                for (int i = 0; i < 3; i++) begin
                    tick(1);
                    seen |= int'(bus_free);
                end
                chk($sformatf("R5 free for idle length %0d", len), seen, int'(VEC[v][0]));
                chk($sformatf("R5 free cleared after idle length %0d", len), int'(bus_free), 0);
                sda_raw = 1'b1;
                tick(3);
            end
        end

        // exact timeout timing, R1 R2 R3
        scl_raw = 1'b0;
        for (int n = 1; n <= LO + DLY + 6; n++) begin
            tick(1);
            chk($sformatf("R1 R2 tmo_flag sample %0d", n), int'(tmo_flag),
                int'(n >= LO + 3 && n <= LO + DLY + 3));
            chk($sformatf("R3 comm_rst sample %0d", n), int'(comm_rst),
                int'(n == LO + DLY + 4));
        end
        // R4 R8 stuck low, longer than the counter range
        pulses = 0;
        seen = 0;
        for (int i = 0; i < 80; i++) begin
            tick(1);
            pulses += int'(comm_rst);
            seen |= int'(tmo_flag);
        end
        chk("R4 R8 no repeat strobe while stuck", pulses, 0);
        chk("R4 R8 no repeat flag while stuck", seen, 0);
        scl_raw = 1'b1;
        tick(4);
        // R4 count restarts: short low after release
        scl_raw = 1'b0;
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            seen |= int'(tmo_flag);
        end
        scl_raw = 1'b1;
        tick(30);
        seen |= int'(tmo_flag);
        chk("R4 count cleared by high clock", seen, 0);

        // R6 exact grant timing with request pending
        sda_raw = 1'b0;
        start_req = 1'b1;
        tick(4);
        sda_raw = 1'b1;
        for (int n = 1; n <= IDL + 4; n++) begin
            tick(1);
            chk($sformatf("R6 grant sample %0d", n), int'(start_grant), int'(n == IDL + 4));
            chk($sformatf("R5 R6 free sample %0d", n), int'(bus_free), int'(n == IDL + 3));
        end
        // R7 no second grant in same idle period
        grants = 0;
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            tick(1);
            grants += int'(start_grant);
            seen |= int'(bus_free);
        end
        chk("R7 no second grant", grants, 0);
        chk("R7 no free after grant", seen, 0);
        // R7 fresh idle period grants again
        sda_raw = 1'b0;
        tick(3);
        sda_raw = 1'b1;
        grants = 0;
        for (int i = 0; i < IDL + 6; i++) begin
            tick(1);
            grants += int'(start_grant);
        end
        chk("R7 grant after fresh idle", grants, 1);
        start_req = 1'b0;

        // R6 free held without request, grant follows request
        sda_raw = 1'b0;
        tick(4);
        sda_raw = 1'b1;
        grants = 0;
        for (int i = 0; i < IDL + 10; i++) begin
            tick(1);
            grants += int'(start_grant);
        end
        chk("R6 no grant without request", grants, 0);
        chk("R5 free held while idle", int'(bus_free), 1);
        start_req = 1'b1;
        tick(1);
        chk("R6 grant one cycle after request", int'(start_grant), 1);
        chk("R6 free low with grant", int'(bus_free), 0);
        tick(1);
        chk("R6 grant single cycle", int'(start_grant), 0);
        start_req = 1'b0;

        // R9 reset during pending timeout
        scl_raw = 1'b0;
        tick(LO + 4);
        chk("R2 flag before reset", int'(tmo_flag), 1);
        rst = 1'b1;
        tick(1);
        chk("R9 flag cleared by reset", int'(tmo_flag), 0);
        chk("R9 strobe low in reset", int'(comm_rst), 0);
        scl_raw = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(DLY + 4);
        chk("R9 no late strobe after reset", int'(comm_rst), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule